// File: doc/BRIEF.md
# Ethernet Receive Header Filter with Rollback

This block takes received Ethernet frames one byte at a time on a valid/ready stream that carries start-of-frame and end-of-frame flags. Every accepted byte of a frame is written into a 4 KB circular packet RAM. A processor reads that RAM through a separate 32-bit read port. While the frame is stored, the block checks fixed header positions against values held on configuration inputs. The checked fields are the destination MAC address, the EtherType, the IPv4 version/header-length byte and the destination IP address. Three further checks can be switched on one at a time: the IP protocol byte and each of the two destination-port bytes.

When a frame passes, the address just past its last byte is published on `commit_addr`. Software detects a new frame by seeing that value change, and it gets the frame length as the difference from the previous value. When a frame fails, the write pointer returns to the frame's first address, so the next frame overwrites the rejected bytes.

Back-pressure rules: `s_ready` is low while reset is applied and high in every cycle after it. The block never stalls the stream. A byte is taken in any cycle where `s_valid` and `s_ready` are both high. The source may insert idle cycles (`s_valid` low) anywhere, including inside a frame.

Top module: `eth_rx_hdr_filter`

## Requirements
- R1: `s_ready` is 0 while `rst_n` is low and 1 from the first clock edge after reset is released. A byte is accepted when `s_valid` and `s_ready` are both 1.
- R2: Each accepted byte of a frame is written at the write pointer, and the pointer then advances by one, wrapping modulo 4096. Byte address A is read on `rd_data[8*(A%4)+7 : 8*(A%4)]` when `rd_addr` = A/4. `rd_data` is registered and appears one clock after `rd_addr` is sampled.
- R3: A frame is rejected unless all of the following hold: bytes 0..5 equal `cfg_dst_mac` with bits 47:40 first; byte 12 = 0x08 and byte 13 = 0x00; byte 14 = 0x45; bytes 30..33 equal `cfg_dst_ip` with bits 31:24 first; and the frame is at least 34 bytes long. Byte numbering starts at 0 on the start-of-frame byte.
- R4: When `cfg_match_en[0]` = 1, byte 23 must equal `cfg_proto`. When it is 0, byte 23 is not checked.
- R5: When `cfg_match_en[1]` = 1, byte 36 must equal `cfg_port_hi`. When `cfg_match_en[2]` = 1, byte 37 must equal `cfg_port_lo`. If either bit is set, a frame shorter than 38 bytes is rejected.
- R6: `commit_addr` resets to 0. On the end-of-frame byte of a passing frame, `commit_addr` takes the address following that byte (modulo 4096) on the same clock edge. At all other times it holds its value.
- R7: On the end-of-frame byte of a failing frame, the write pointer returns to the address of that frame's first byte. The next frame is stored from that address.
- R8: An accepted byte that carries no start-of-frame flag while no frame is open is ignored. It writes nothing, does not move the pointer, and does not change `commit_addr`.
- R9: A start-of-frame byte that arrives while a frame is still open abandons the open frame. The new frame is stored from the abandoned frame's first address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream ready (high except in reset) |
| s_data | input | 8 | Stream byte |
| s_sop | input | 1 | First byte of a frame |
| s_eop | input | 1 | Last byte of a frame |
| cfg_dst_mac | input | 48 | Expected destination MAC |
| cfg_dst_ip | input | 32 | Expected destination IPv4 address |
| cfg_match_en | input | 3 | Optional checks: [0] protocol, [1] port high byte, [2] port low byte |
| cfg_proto | input | 8 | Expected protocol byte |
| cfg_port_hi | input | 8 | Expected byte 36 |
| cfg_port_lo | input | 8 | Expected byte 37 |
| rd_addr | input | 10 | Processor word address |
| rd_data | output | 32 | Processor read data, one-cycle latency |
| commit_addr | output | 12 | Address after the last committed frame |

## Verification
The bench builds the block with its default parameters: a 12-bit byte pointer, four bytes per read word, and a 6-bit saturating header index. With these values, a handful of 1000-byte frames is enough to carry the write pointer and `commit_addr` across the 4095-to-0 wrap, and to check reads of words on both sides of it. The frames are also built to probe the exact length limits of 33/34 and 37/38 bytes. Rejected frames are placed at aligned bases, so that a following good frame can be read back word by word to show its bytes replaced the rejected ones.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;
  localparam int MAC_POS      = 0;
  localparam int MAC_BYTES    = 6;
  localparam int ETYPE_POS    = 12;
  localparam int VIHL_POS     = 14;
  localparam int PROTO_POS    = 23;
  localparam int IP_POS       = 30;
  localparam int IP_BYTES     = 4;
  localparam int PORT_HI_POS  = 36;
  localparam int PORT_LO_POS  = 37;
  localparam int MIN_LEN      = 34;
  localparam int PORT_MIN_LEN = 38;

  localparam logic [7:0] ETYPE_HI = 8'h08;
  localparam logic [7:0] ETYPE_LO = 8'h00;
  localparam logic [7:0] VIHL_V4  = 8'h45;

  typedef struct packed {
    logic [47:0] mac;
    logic [31:0] ip;
    logic [2:0]  en;
    logic [7:0]  proto;
    logic [7:0]  port_hi;
    logic [7:0]  port_lo;
  } filt_cfg_t;
endpackage

// File: rtl/eth_rxf_hdr_chk.sv
module eth_rxf_hdr_chk
  import eth_rxf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       sop,
  input  logic       eop,
  input  logic [7:0] data,
  input  filt_cfg_t  cfg,
  output logic       pass_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q, cur_idx;
  logic             err_q, err_prev, mis, too_short, port_short, port_need;

  always_comb begin
    cur_idx  = sop ? '0 : idx_q;
    err_prev = sop ? 1'b0 : err_q;
    mis      = 1'b0;
    for (int k = 0; k < MAC_BYTES; k++) begin
      if (cur_idx == IDX_W'(MAC_POS + k) && data != cfg.mac[47-8*k -: 8]) mis = 1'b1;
    end
    for (int k = 0; k < IP_BYTES; k++) begin
      if (cur_idx == IDX_W'(IP_POS + k) && data != cfg.ip[31-8*k -: 8]) mis = 1'b1;
    end
    if (cur_idx == IDX_W'(ETYPE_POS)     && data != ETYPE_HI) mis = 1'b1;
    if (cur_idx == IDX_W'(ETYPE_POS + 1) && data != ETYPE_LO) mis = 1'b1;
    if (cur_idx == IDX_W'(VIHL_POS)      && data != VIHL_V4)  mis = 1'b1;
    if (cfg.en[0] && cur_idx == IDX_W'(PROTO_POS)   && data != cfg.proto)   mis = 1'b1;
    if (cfg.en[1] && cur_idx == IDX_W'(PORT_HI_POS) && data != cfg.port_hi) mis = 1'b1;
    if (cfg.en[2] && cur_idx == IDX_W'(PORT_LO_POS) && data != cfg.port_lo) mis = 1'b1;
    port_need  = cfg.en[1] | cfg.en[2];
    too_short  = cur_idx < IDX_W'(MIN_LEN - 1);
    port_short = port_need && (cur_idx < IDX_W'(PORT_MIN_LEN - 1));
    pass_o     = !(err_prev | mis | too_short | port_short);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else if (beat) begin
      idx_q <= (cur_idx == IDX_MAX || eop) ? cur_idx : cur_idx + 1'b1;
      err_q <= err_prev | mis;
    end
  end

  // R3: a frame ending before byte 33 can never pass
  a_r3_short_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && eop && (idx_q < IDX_W'(MIN_LEN - 1)) && !sop) |-> !pass_o);
endmodule

// File: rtl/eth_rxf_wptr.sv
module eth_rxf_wptr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              sop,
  input  logic              eop,
  input  logic              pass_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] commit_o
);
  logic              in_frame_q;
  logic [ADDR_W-1:0] ptr_q, base_q, base_now, commit_q;

  always_comb begin
    wr_en_o   = acc & (in_frame_q | sop);
    wr_addr_o = (sop && in_frame_q) ? base_q : ptr_q;
    base_now  = sop ? wr_addr_o : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      ptr_q      <= '0;
      base_q     <= '0;
      commit_q   <= '0;
    end else if (wr_en_o) begin
      base_q <= base_now;
      if (eop) begin
        in_frame_q <= 1'b0;
        if (pass_i) begin
          ptr_q    <= wr_addr_o + 1'b1;
          commit_q <= wr_addr_o + 1'b1;
        end else begin
          ptr_q <= base_now;
        end
      end else begin
        in_frame_q <= 1'b1;
        ptr_q      <= wr_addr_o + 1'b1;
      end
    end
  end

  assign commit_o = commit_q;

  a_r7_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && eop && !pass_i) |=> (ptr_q == $past(base_now)));

  a_r6_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && eop && pass_i) |=> $stable(commit_q));

  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !eop) |=> (ptr_q == ADDR_W'($past(wr_addr_o) + 1'b1)));

  a_r8_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_frame_q && !sop) |=> ($stable(ptr_q) && $stable(commit_q)));
endmodule

// File: rtl/eth_rxf_pkt_ram.sv
module eth_rxf_pkt_ram #(
  parameter int ADDR_W   = 12,
  parameter int RD_BYTES = 4
) (
  input  logic                                clk,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [7:0]                          wr_data,
  input  logic [ADDR_W-$clog2(RD_BYTES)-1:0]  rd_addr,
  output logic [8*RD_BYTES-1:0]               rd_data
);
  localparam int LANE_W = $clog2(RD_BYTES);
  localparam int WA_W   = ADDR_W - LANE_W;
  localparam int WORDS  = 1 << WA_W;

  logic [WA_W-1:0]   wr_word;
  logic [LANE_W-1:0] wr_lane;

  assign wr_word = wr_addr[ADDR_W-1:LANE_W];
  assign wr_lane = wr_addr[LANE_W-1:0];

  for (genvar g = 0; g < RD_BYTES; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_lane == LANE_W'(g)) mem[wr_word] <= wr_data;
      rd_data[8*g +: 8] <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/eth_rx_hdr_filter.sv
module eth_rx_hdr_filter
  import eth_rxf_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RD_BYTES = 4,
  parameter int IDX_W    = 6,
  localparam int RA_W    = ADDR_W - $clog2(RD_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [7:0]              s_data,
  input  logic                    s_sop,
  input  logic                    s_eop,
  input  logic [47:0]             cfg_dst_mac,
  input  logic [31:0]             cfg_dst_ip,
  input  logic [2:0]              cfg_match_en,
  input  logic [7:0]              cfg_proto,
  input  logic [7:0]              cfg_port_hi,
  input  logic [7:0]              cfg_port_lo,
  input  logic [RA_W-1:0]         rd_addr,
  output logic [8*RD_BYTES-1:0]   rd_data,
  output logic [ADDR_W-1:0]       commit_addr
);
  filt_cfg_t         cfg;
  logic              ready_q, acc, wr_en, pass;
  logic [ADDR_W-1:0] wr_addr;

  assign cfg = '{mac: cfg_dst_mac, ip: cfg_dst_ip, en: cfg_match_en,
                 proto: cfg_proto, port_hi: cfg_port_hi, port_lo: cfg_port_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign s_ready = ready_q;
  assign acc     = s_valid & ready_q;

  eth_rxf_wptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sop(s_sop), .eop(s_eop),
    .pass_i(pass), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .commit_o(commit_addr)
  );

  eth_rxf_hdr_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .beat(wr_en), .sop(s_sop), .eop(s_eop),
    .data(s_data), .cfg(cfg), .pass_o(pass)
  );

  eth_rxf_pkt_ram #(.ADDR_W(ADDR_W), .RD_BYTES(RD_BYTES)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(s_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/eth_rx_hdr_filter_tb_top.sv
`timescale 1ns/1ps
module eth_rx_hdr_filter_tb_top;
  typedef logic [7:0] bytes_t [$];

  localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;
  localparam logic [31:0] IP  = 32'hC0A8_0107;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0, s_ready;
  logic [7:0]  s_data = '0;
  logic [2:0]  cfg_match_en = '0;
  logic [7:0]  cfg_proto = 8'h11, cfg_port_hi = 8'h0F, cfg_port_lo = 8'hA0;
  logic [9:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [11:0] commit_addr;

  int checks = 0, failures = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  eth_rx_hdr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sop(s_sop), .s_eop(s_eop), .cfg_dst_mac(MAC), .cfg_dst_ip(IP),
    .cfg_match_en(cfg_match_en), .cfg_proto(cfg_proto), .cfg_port_hi(cfg_port_hi),
    .cfg_port_lo(cfg_port_lo), .rd_addr(rd_addr), .rd_data(rd_data), .commit_addr(commit_addr)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [7:0] mem_m [4096];
  int  m_ptr = 0, m_base = 0, m_commit = 0;
  bit  m_in = 0, m_ready = 0;
  bytes_t m_q;

  function automatic bit frame_ok(bytes_t q);
    int n = q.size();
    if (n < 34) return 0;
    for (int k = 0; k < 6; k++) if (q[k] != MAC[47-8*k -: 8]) return 0;
    for (int k = 0; k < 4; k++) if (q[30+k] != IP[31-8*k -: 8]) return 0;
    if (q[12] != 8'h08 || q[13] != 8'h00 || q[14] != 8'h45) return 0;
    if (cfg_match_en[0] && q[23] != cfg_proto) return 0;
    if ((cfg_match_en[1] || cfg_match_en[2]) && n < 38) return 0;
    if (cfg_match_en[1] && q[36] != cfg_port_hi) return 0;
    if (cfg_match_en[2] && q[37] != cfg_port_lo) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready = 0; m_ptr = 0; m_base = 0; m_commit = 0; m_in = 0;
    end else begin
      if (s_valid && m_ready) begin
        if (s_sop) begin
          if (m_in) m_ptr = m_base;
          m_base = m_ptr; m_q.delete(); m_in = 1;
        end
        if (m_in) begin
          mem_m[m_ptr] = s_data;
          m_q.push_back(s_data);
          m_ptr = (m_ptr + 1) % 4096;
          if (s_eop) begin
            m_in = 0;
            if (frame_ok(m_q)) m_commit = m_ptr;
            else m_ptr = m_base;
          end
        end
      end
      m_ready = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R6 per-clock commit_addr vs model", commit_addr, m_commit);
      chk("R1 per-clock s_ready vs model", s_ready, m_ready);
    end
  end

  function automatic bytes_t mk(int len, logic [47:0] mac, logic [31:0] ip, logic [15:0] et,
                                logic [7:0] vihl, logic [7:0] proto, logic [7:0] ph,
                                logic [7:0] pl, logic [7:0] seed);
    bytes_t q;
    for (int i = 0; i < len; i++) q.push_back(seed + 8'(i));
    for (int k = 0; k < 6; k++) if (k < len) q[k] = mac[47-8*k -: 8];
    for (int k = 0; k < 4; k++) if (30 + k < len) q[30+k] = ip[31-8*k -: 8];
    if (12 < len) q[12] = et[15:8];
    if (13 < len) q[13] = et[7:0];
    if (14 < len) q[14] = vihl;
    if (23 < len) q[23] = proto;
    if (36 < len) q[36] = ph;
    if (37 < len) q[37] = pl;
    return q;
  endfunction

  function automatic bytes_t good(int len, logic [7:0] seed);
    return mk(len, MAC, IP, 16'h0800, 8'h45, 8'h11, 8'h0F, 8'hA0, seed);
  endfunction

  task automatic send(bytes_t q, bit do_sop, bit do_eop, int gap);
    for (int i = 0; i < q.size(); i++) begin
      s_valid = 1; s_data = q[i];
      s_sop = do_sop && (i == 0);
      s_eop = do_eop && (i == q.size() - 1);
      @(negedge clk);
      if (gap != 0 && (i % gap) == gap - 1) begin
        s_valid = 0; s_sop = 0; s_eop = 0;
        @(negedge clk);
      end
    end
    s_valid = 0; s_sop = 0; s_eop = 0;
  endtask

  task automatic rd_word(int baddr, output logic [31:0] w);
    rd_addr = 10'(baddr >> 2);
    @(negedge clk);
    w = rd_data;
  endtask

  task automatic rd_chk(string tag, int baddr);
    logic [31:0] w;
    int b = (baddr >> 2) * 4;
    rd_word(baddr, w);
    chk(tag, w, {mem_m[b+3], mem_m[b+2], mem_m[b+1], mem_m[b]});
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bytes_t q;
    logic [31:0] w;
    int exp_c = 0;
    repeat (3) @(negedge clk);
    chk("R1 s_ready low in reset", s_ready, 0);
    chk("R6 commit_addr reset value", commit_addr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 s_ready high after reset", s_ready, 1);
    cmp_en = 1;

    // R3/R6 basic pass
    send(good(60, 8'h00), 1, 1, 0); exp_c = 60;
    chk("R6 commit after good frame", commit_addr, exp_c);
    for (int a = 0; a < 60; a += 12) rd_chk("R2 stored bytes readback", a);

    // R7 rollback then overwrite
    send(mk(60, MAC ^ 48'h1, IP, 16'h0800, 8'h45, 8'h11, 8'h0F, 8'hA0, 8'h80), 1, 1, 0);
    chk("R3 wrong MAC rejected", commit_addr, exp_c);
    q = good(40, 8'h40);
    send(q, 1, 1, 2); exp_c = 100;
    chk("R7 frame after reject stored from rejected base", commit_addr, exp_c);
    rd_word(60, w);
    chk("R7 rejected bytes overwritten", w, {q[3], q[2], q[1], q[0]});

    // R3 other mandatory fields
    send(mk(60, MAC, IP, 16'h86DD, 8'h45, 8'h11, 8'h0F, 8'hA0, 8'h10), 1, 1, 0);
    chk("R3 wrong EtherType rejected", commit_addr, exp_c);
    send(mk(60, MAC, IP, 16'h0800, 8'h46, 8'h11, 8'h0F, 8'hA0, 8'h10), 1, 1, 0);
    chk("R3 IHL not 5 rejected", commit_addr, exp_c);
    send(mk(60, MAC, IP ^ 32'h100, 16'h0800, 8'h45, 8'h11, 8'h0F, 8'hA0, 8'h10), 1, 1, 0);
    chk("R3 wrong IP rejected", commit_addr, exp_c);
    send(good(33, 8'h20), 1, 1, 0);
    chk("R3 33-byte frame rejected", commit_addr, exp_c);
    send(good(34, 8'h21), 1, 1, 0); exp_c = 134;
    chk("R3 34-byte frame accepted", commit_addr, exp_c);

    // R4 protocol check
    cfg_match_en = 3'b001;
    send(mk(40, MAC, IP, 16'h0800, 8'h45, 8'h06, 8'h0F, 8'hA0, 8'h30), 1, 1, 0);
    chk("R4 protocol mismatch rejected", commit_addr, exp_c);
    send(good(40, 8'h31), 1, 1, 0); exp_c = 174;
    chk("R4 protocol match accepted", commit_addr, exp_c);
    cfg_match_en = 3'b000;
    send(mk(40, MAC, IP, 16'h0800, 8'h45, 8'h01, 8'h0F, 8'hA0, 8'h32), 1, 1, 0); exp_c = 214;
    chk("R4 protocol ignored when disabled", commit_addr, exp_c);

    // R5 port checks
    cfg_match_en = 3'b010;
    send(mk(40, MAC, IP, 16'h0800, 8'h45, 8'h11, 8'h0E, 8'hA0, 8'h33), 1, 1, 0);
    chk("R5 byte36 mismatch rejected", commit_addr, exp_c);
    cfg_match_en = 3'b100;
    send(mk(40, MAC, IP, 16'h0800, 8'h45, 8'h11, 8'h0E, 8'hA0, 8'h34), 1, 1, 0); exp_c = 254;
    chk("R5 byte36 ignored when bit1 clear", commit_addr, exp_c);
    send(mk(40, MAC, IP, 16'h0800, 8'h45, 8'h11, 8'h0F, 8'hA1, 8'h35), 1, 1, 0);
    chk("R5 byte37 mismatch rejected", commit_addr, exp_c);
    cfg_match_en = 3'b110;
    send(good(37, 8'h36), 1, 1, 0);
    chk("R5 37-byte frame rejected with port check", commit_addr, exp_c);
    send(good(38, 8'h37), 1, 1, 0); exp_c = 292;
    chk("R5 38-byte frame accepted with port check", commit_addr, exp_c);
    cfg_match_en = 3'b111;
    send(good(64, 8'h38), 1, 1, 3); exp_c = 356;
    chk("R5 all optional checks with idle gaps", commit_addr, exp_c);
    cfg_match_en = 3'b000;

    // R8 stray bytes
    send(good(20, 8'hC0), 0, 1, 0);
    chk("R8 stray bytes leave commit", commit_addr, exp_c);
    q = good(40, 8'h50);
    send(q, 1, 1, 0); exp_c = 396;
    chk("R8 stray bytes did not move pointer", commit_addr, exp_c);
    rd_word(356, w);
    chk("R8 stray bytes not stored", w, {q[3], q[2], q[1], q[0]});

    // R9 restart
    send(good(20, 8'hD0), 1, 0, 0);
    q = good(44, 8'h60);
    send(q, 1, 1, 0); exp_c = 440;
    chk("R9 restart stores from abandoned base", commit_addr, exp_c);
    rd_word(396, w);
    chk("R9 restart bytes at abandoned base", w, {q[3], q[2], q[1], q[0]});

    // R2 wrap
    for (int f = 0; f < 4; f++) send(good(1000, 8'(f)), 1, 1, 0);
    exp_c = 344;
    chk("R2 pointer wraps modulo 4096", commit_addr, exp_c);
    rd_chk("R2 read before wrap", 4092);
    rd_chk("R2 read at wrap", 0);
    rd_chk("R2 read after wrap", 100);
    send(mk(60, MAC, IP, 16'h0800, 8'h45, 8'h11, 8'h0F, 8'hA0, 8'hE0) , 1, 1, 0);
    exp_c = 404;
    chk("R6 commit after wrap", commit_addr, exp_c);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule